// File: doc/BRIEF.md
# GF(3^97) Cubing Unit

This block raises an element of the field GF(3^97) to the third power. Field elements are polynomials of degree below 97 over GF(3), reduced modulo f(x) = x^97 + x^12 + 2. In characteristic three the map a -> a^3 is linear. Each input coefficient a_i therefore moves to the monomial x^(3i), and those monomials are then folded back below degree 97. With this modulus every output coefficient ends up as a signed sum of at most three input coefficients. The whole map is a fixed network of wires, GF(3) negations and adders with at most three operands.

The unit has a single register stage. A strobed input produces the cube on the output one clock later, together with a valid flag. A host raises an element to 3^k by feeding the output back to the input k times. The connection table is not written out by hand. It is derived during elaboration from the reduction rule x^97 = 2x^12 + 1.

Top module: `gf3p97_cube`

## Requirements
- R1: Coefficient i of an element sits at bits [2i+1:2i] and is coded 00 = 0, 01 = 1, 10 = 2. The code 11 never appears on `cube_out` when the inputs use only these codes.
- R2: When the data is accepted, `cube_out` equals `elem_in`^3 reduced modulo x^97 + x^12 + 2. This equals `elem_in`·`elem_in`·`elem_in` computed by polynomial multiplication and reduction.
- R3: Output coefficient 0 equals a0 + a89 + a93 over GF(3).
- R4: Output coefficient 1 equals a65 minus a61 over GF(3).
- R5: Output coefficient 2 is a copy of a33, and output coefficient 96 is a copy of a32.
- R6: Output coefficient 3 equals a1 + a90 + a94 over GF(3).
- R7: `cube_vld` is `elem_vld` delayed by exactly one clock. In the cycle it rises, `cube_out` holds the cube of the element presented with the strobe.
- R8: While `elem_vld` is low, `cube_out` keeps its value whatever `elem_in` carries.
- R9: A synchronous active-high reset clears `cube_vld` and sets `cube_out` to the zero element.
- R10: Cubing any element 97 times in succession, feeding the output back, gives the original element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| elem_vld | input | 1 | Strobe: `elem_in` carries an element to cube |
| elem_in | input | 194 | Element to cube, 97 coefficients of 2 bits |
| cube_vld | output | 1 | `cube_out` was loaded in the previous clock |
| cube_out | output | 194 | Registered cube of the last accepted element |

## Verification
The assertions assume that every strobed input coefficient uses one of the three legal codes. The unit itself does not define what an 11 code means. The bench builds all its stimulus from values in 0..2, so the illegal code never reaches the input. Between strobes the bench drives `elem_in` with other legal elements, which shows that the hold behaviour does not depend on what sits on the bus. The 97-step feedback test drives each new input from the previous registered output, so every strobed value is one the unit produced itself.

// File: rtl/gf3p97_cube_pkg.sv
package gf3p97_cube_pkg;

    // Field size and the middle exponent of the modulus x^M + x^K + 2.
    localparam int M         = 97;
    localparam int K         = 12;
    localparam int W         = 2 * M;
    localparam int IDX_W     = $clog2(M);
    localparam int MAX_TERMS = 3;
    localparam int POW_LEN   = 3 * M - 2;   // degrees 0 .. 3(M-1)
    localparam int FOLD_GAP  = M - K;       // x^k -> x^(k-FOLD_GAP) term

    typedef logic [1:0] trit_t;             // 0, 1, 2 ; 3 is illegal

    typedef struct packed {
        trit_t            coef;             // 0 marks an unused slot
        logic [IDX_W-1:0] src;              // input coefficient index
    } tap_t;

    typedef tap_t  [MAX_TERMS-1:0] tap_row_t;
    typedef tap_row_t [M-1:0]      cube_map_t;

    function automatic trit_t gf3_add(trit_t a, trit_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

    function automatic trit_t gf3_neg(trit_t a);
        return {a[0], a[1]};
    endfunction

    function automatic trit_t gf3_sub(trit_t a, trit_t b);
        return gf3_add(a, gf3_neg(b));
    endfunction

    function automatic trit_t gf3_scale(trit_t c, trit_t a);
        case (c)
            2'd1:    return a;
            2'd2:    return gf3_neg(a);
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic elem_is_canonical(logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < M; i++) begin
            if (v[2*i +: 2] == 2'b11) ok = 1'b0;
        end
        return ok;
    endfunction

    // For each output coefficient, list the signed input taps. Each x^(3i)
    // is folded below degree M using x^M = 2x^K + 1.
    function automatic cube_map_t build_cube_map();
        cube_map_t               mp;
        logic [POW_LEN-1:0][1:0] pw;
        logic [M-1:0][1:0]       cnt;
        trit_t                   v;
        int                      c;
        mp  = '0;
        cnt = '0;
        for (int i = 0; i < M; i++) begin
            pw        = '0;
            pw[3*i]   = 2'd1;
            for (int k = POW_LEN - 1; k >= M; k--) begin
                v = pw[k];
                if (v != 2'd0) begin
                    pw[k]            = 2'd0;
                    pw[k - FOLD_GAP] = gf3_add(pw[k - FOLD_GAP], gf3_neg(v));
                    pw[k - M]        = gf3_add(pw[k - M], v);
                end
            end
            for (int j = 0; j < M; j++) begin
                c = int'(cnt[j]);
                if (pw[j] != 2'd0 && c < MAX_TERMS) begin
                    mp[j][c].coef = pw[j];
                    mp[j][c].src  = IDX_W'(i);
                    cnt[j]        = cnt[j] + 2'd1;
                end
            end
        end
        return mp;
    endfunction

endpackage

// File: rtl/gf3_tap_sum.sv
module gf3_tap_sum
    import gf3p97_cube_pkg::*;
#(
    parameter tap_row_t TAPS = '0
) (
    input  trit_t [MAX_TERMS-1:0] terms,
    output trit_t                 sum
);
    trit_t [MAX_TERMS:0] partial;

    assign partial[0] = 2'd0;

    for (genvar t = 0; t < MAX_TERMS; t++) begin : g_term
        if (TAPS[t].coef == 2'd0) begin : g_idle
            assign partial[t+1] = partial[t];
        end else begin : g_live
            assign partial[t+1] = gf3_add(partial[t],
                                          gf3_scale(TAPS[t].coef, terms[t]));
        end
    end

    assign sum = partial[MAX_TERMS];

    logic unused_terms;
    assign unused_terms = ^terms;

endmodule

// File: rtl/gf3p97_cube_net.sv
module gf3p97_cube_net
    import gf3p97_cube_pkg::*;
(
    input  logic [W-1:0] a,
    output logic [W-1:0] b
);
    localparam cube_map_t MAP = build_cube_map();

    for (genvar j = 0; j < M; j++) begin : g_coef
        trit_t [MAX_TERMS-1:0] terms;
        trit_t                 res;

        for (genvar t = 0; t < MAX_TERMS; t++) begin : g_pick
            localparam int SRC = int'(MAP[j][t].src);
            assign terms[t] = a[2*SRC +: 2];
        end

        gf3_tap_sum #(.TAPS(MAP[j])) u_sum (
            .terms (terms),
            .sum   (res)
        );

        assign b[2*j +: 2] = res;
    end

endmodule

// File: rtl/gf3p97_cube.sv
module gf3p97_cube
    import gf3p97_cube_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                elem_vld,
    input  logic [2*97-1:0]     elem_in,
    output logic                cube_vld,
    output logic [2*97-1:0]     cube_out
);
    logic [W-1:0] cube_comb;

    gf3p97_cube_net u_net (
        .a (elem_in),
        .b (cube_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cube_vld <= 1'b0;
            cube_out <= '0;
        end else begin
            cube_vld <= elem_vld;
            if (elem_vld) cube_out <= cube_comb;
        end
    end

    AST_IN_CANONICAL: assert property (@(posedge clk) disable iff (rst)
        elem_vld |-> elem_is_canonical(elem_in));                      // R1
    AST_OUT_CANONICAL: assert property (@(posedge clk) disable iff (rst)
        elem_is_canonical(cube_out));                                  // R1
    AST_B1_DIFF: assert property (@(posedge clk) disable iff (rst)
        elem_vld |=> cube_out[3:2] ==
            gf3_sub($past(elem_in[131:130]), $past(elem_in[123:122]))); // R4
    AST_B2_WIRE: assert property (@(posedge clk) disable iff (rst)
        elem_vld |=> cube_out[5:4] == $past(elem_in[67:66]));          // R5
    AST_B96_WIRE: assert property (@(posedge clk) disable iff (rst)
        elem_vld |=> cube_out[193:192] == $past(elem_in[65:64]));      // R5
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        elem_vld |=> cube_vld);                                        // R7
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        !elem_vld |=> !cube_vld);                                      // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !elem_vld |=> $stable(cube_out));                              // R8

endmodule

// File: tb/gf3p97_cube_bench.sv
module gf3p97_cube_bench;
    import gf3p97_cube_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          elem_vld = 1'b0;
    logic [W-1:0]  elem_in = '0;
    logic          cube_vld;
    logic [W-1:0]  cube_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;   // 50 MHz

    gf3p97_cube u_gf3p97_cube (
        .clk      (clk),
        .rst      (rst),
        .elem_vld (elem_vld),
        .elem_in  (elem_in),
        .cube_vld (cube_vld),
        .cube_out (cube_out)
    );

    function automatic int cf(logic [W-1:0] v, int i);
        return int'(v[2*i +: 2]);
    endfunction

    function automatic logic [W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y);
        int p [2*M-1];
        logic [W-1:0] r;
        for (int k = 0; k < 2*M-1; k++) p[k] = 0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                p[i+j] = (p[i+j] + cf(x, i) * cf(y, j)) % 3;
        for (int k = 2*M-2; k >= M; k--) begin
            p[k-(M-K)] = (p[k-(M-K)] + 2 * p[k]) % 3;
            p[k-M]     = (p[k-M] + p[k]) % 3;
            p[k]       = 0;
        end
        r = '0;
        for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(p[i]);
        return r;
    endfunction

    function automatic logic [W-1:0] ref_cube(logic [W-1:0] x);
        return ref_mul(ref_mul(x, x), x);
    endfunction

    function automatic logic [W-1:0] monomial(int i, int c);
        logic [W-1:0] r;
        r = '0;
        r[2*i +: 2] = 2'(c);
        return r;
    endfunction

    task automatic rand_elem(output logic [W-1:0] e);
        e = '0;
        for (int i = 0; i < M; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            e[2*i +: 2] = 2'(lfsr[15:0] % 3);
        end
    endtask

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Strobe one element; returns at the negedge after the capturing edge.
    task automatic apply(logic [W-1:0] e);
        @(negedge clk);
        elem_vld = 1'b1;
        elem_in  = e;
        @(negedge clk);
        elem_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9", "valid after reset", W'(cube_vld), W'(0));
        chk("R9", "data after reset", cube_out, '0);
    endtask

    task automatic t_monomials();
        int idx [6] = '{0, 1, 32, 33, 61, 96};
        foreach (idx[n]) begin
            logic [W-1:0] e;
            e = monomial(idx[n], 2);
            apply(e);
            chk("R2", "monomial cube", cube_out, ref_cube(e));
        end
    endtask

    task automatic t_formulas();
        for (int n = 0; n < 4; n++) begin
            logic [W-1:0] e;
            rand_elem(e);
            apply(e);
            chk("R2", "random cube", cube_out, ref_cube(e));
            chk("R3", "coef 0", W'(cf(cube_out, 0)),
                W'((cf(e, 0) + cf(e, 89) + cf(e, 93)) % 3));
            chk("R4", "coef 1", W'(cf(cube_out, 1)),
                W'((cf(e, 65) + 3 - cf(e, 61)) % 3));
            chk("R5", "coef 2", W'(cf(cube_out, 2)), W'(cf(e, 33)));
            chk("R5", "coef 96", W'(cf(cube_out, 96)), W'(cf(e, 32)));
            chk("R6", "coef 3", W'(cf(cube_out, 3)),
                W'((cf(e, 1) + cf(e, 90) + cf(e, 94)) % 3));
            chk("R1", "no code 11", W'(elem_is_canonical(cube_out)), W'(1));
        end
        begin
            logic [W-1:0] all2;
            for (int i = 0; i < M; i++) all2[2*i +: 2] = 2'd2;
            apply(all2);
            chk("R2", "all-two cube", cube_out, ref_cube(all2));
            chk("R1", "all-two canonical", W'(elem_is_canonical(cube_out)), W'(1));
        end
    endtask

    task automatic t_latency_hold();
        logic [W-1:0] e1;
        logic [W-1:0] e2;
        rand_elem(e1);
        rand_elem(e2);
        apply(e1);
        chk("R7", "valid one cycle later", W'(cube_vld), W'(1));
        chk("R7", "data with valid", cube_out, ref_cube(e1));
        elem_in = e2;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R7", "valid low when idle", W'(cube_vld), W'(0));
            chk("R8", "data held while idle", cube_out, ref_cube(e1));
        end
        // back-to-back strobes
        @(negedge clk);
        elem_vld = 1'b1;
        elem_in  = e2;
        @(negedge clk);
        chk("R7", "first of pair", cube_out, ref_cube(e2));
        elem_in  = e1;
        @(negedge clk);
        elem_vld = 1'b0;
        chk("R7", "second of pair", cube_out, ref_cube(e1));
        chk("R7", "valid stays high", W'(cube_vld), W'(1));
    endtask

    task automatic t_orbit(logic [W-1:0] start);
        logic [W-1:0] cur;
        cur = start;
        for (int s = 0; s < M; s++) begin
            apply(cur);
            cur = cube_out;
        end
        chk("R10", "97 cubings return input", cur, start);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_monomials();
        t_formulas();
        t_latency_hold();
        t_orbit(monomial(1, 1));
        begin
            logic [W-1:0] e;
            rand_elem(e);
            t_orbit(e);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule